// File: doc/BRIEF.md
# Cartridge Address Mapper

The mapper sits between a CPU bus and the memories on a cartridge. On every clock it takes the 24-bit CPU address, which is an 8-bit bank above a 16-bit offset, together with a word of committed control flags. It works out which memory the access is for: program ROM, a 512 KB pseudo-static RAM, flash, or none of them. It also computes the physical address inside that memory. The result is registered, so it appears one cycle after the address is sampled.

The address windows overlap. A fixed priority order settles which one wins. Some windows are switched on or off by single flags. When such a window is switched off, the address is tested against the lower-priority windows that follow it. The broad fallback window can use linear translation or fold each bank to 32 KB, and a flag picks whether it targets flash or RAM. An address that falls in no window is an open-bus cycle. In that case the mapper hands back the data-bus value from the previous cycle.

Every physical address is mirrored into its target by masking it with the target's size minus one. All three sizes are parameters and must be powers of two.

Top module: `cart_addr_mapper`

## Requirements
- R1: With flag bit 7 set, banks 0x00-0x1F at offsets 0x8000-0xFFFF select ROM at address {bank[4:0], offset[14:0]}. This window has the highest priority.
- R2: With flag bit 8 set, banks 0x80-0x9F at offsets 0x8000-0xFFFF select ROM at the same folded address {bank[4:0], offset[14:0]}. Flag bit 7 has no effect on these banks.
- R3: Banks 0x20-0x3F at offsets 0x6000-0x7FFF always select RAM at the untranslated 24-bit address. No flag affects this.
- R4: Banks 0x40-0x4F select RAM at address[19:0] when flag bit 5 is clear. Banks 0x50-0x5F do the same when flag bit 6 is clear. When the controlling flag is set, the address falls through to R7.
- R5: Banks 0x60-0x6F select RAM at address[19:0] when flag bit 3 is set. Otherwise the address falls through to R7.
- R6: Banks 0x70-0x77 always select RAM at address[18:0], ahead of the fallback window.
- R7: The fallback window covers offsets 0x8000-0xFFFF of banks 0x00-0x3F and 0x80-0xBF, and every offset of banks 0x40-0x7F and 0xC0-0xFF.
  - With flag bit 2 clear, the address is folded to {bank[6:0], offset[14:0]}. With flag bit 2 set, it is address[22:0].
  - The target is flash when flag bit 1 is clear and RAM when it is set.
- R8: An address that matches no window selects open bus.
  - The physical address is then 0, and `open_data` shows the `bus_data` value sampled one cycle before the address.
  - On any other access, `open_data` is 0.
- R9: The physical address is the translated address ANDed with the target's size minus one. The sizes are ROM_BYTES (default 512 KB), RAM_BYTES (512 KB) and FLASH_BYTES (4 MB).
- R10: `tgt_sel` is one-hot: bit 0 ROM, bit 1 RAM, bit 2 flash, bit 3 open bus.
  - Outputs change one clock after the address is sampled.
  - In reset, `tgt_sel` is 4'b1000, and `phys_addr` and `open_data` are 0.
- R11: Flag bits 0, 4 and 9-15 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 24 | CPU bus address: bank in [23:16], offset in [15:0] |
| bus_data | input | 8 | Current value on the CPU data bus |
| flags | input | 16 | Committed control flags |
| tgt_sel | output | 4 | One-hot target: ROM, RAM, flash, open bus |
| phys_addr | output | PA_W (22) | Mirrored physical address within the target |
| open_bus | output | 1 | High when no window matched |
| open_data | output | 8 | Data-bus value to return on an open-bus cycle |

## Verification
The hardest case to reach is a flag-gated window that has been switched off. From the ports, this falls-through case looks like an ordinary fallback hit, because in both cases the result is flash or RAM with some address. The stimulus therefore drives one address twice, once with the gating flag set and once with it clear. The fallback's flags are chosen so that its target and folded address differ clearly from those of the gated window. The open-bus data path is exercised by changing `bus_data` in the same cycle the unmapped address is applied. This shows that the value returned is the one from the cycle before.

// File: rtl/cart_addr_mapper.sv
module cart_addr_mapper #(
  parameter int ROM_BYTES   = 512 * 1024,
  parameter int RAM_BYTES   = 512 * 1024,
  parameter int FLASH_BYTES = 4 * 1024 * 1024,
  localparam int ROM_AW   = $clog2(ROM_BYTES),
  localparam int RAM_AW   = $clog2(RAM_BYTES),
  localparam int FLASH_AW = $clog2(FLASH_BYTES),
  localparam int PA_W = (ROM_AW > RAM_AW)
                        ? ((ROM_AW > FLASH_AW) ? ROM_AW : FLASH_AW)
                        : ((RAM_AW > FLASH_AW) ? RAM_AW : FLASH_AW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [23:0]     cpu_addr,
  input  logic [7:0]      bus_data,
  input  logic [15:0]     flags,
  output logic [3:0]      tgt_sel,
  output logic [PA_W-1:0] phys_addr,
  output logic            open_bus,
  output logic [7:0]      open_data
);
  localparam int F_FB_RAM  = 1;
  localparam int F_LINEAR  = 2;
  localparam int F_RAM60   = 3;
  localparam int F_HIDE40  = 5;
  localparam int F_HIDE50  = 6;
  localparam int F_ROM_LO  = 7;
  localparam int F_ROM_HI  = 8;

  localparam logic [3:0] S_ROM   = 4'b0001;
  localparam logic [3:0] S_RAM   = 4'b0010;
  localparam logic [3:0] S_FLASH = 4'b0100;
  localparam logic [3:0] S_OPEN  = 4'b1000;

  localparam logic [23:0] ROM_MASK   = 24'(ROM_BYTES - 1);
  localparam logic [23:0] RAM_MASK   = 24'(RAM_BYTES - 1);
  localparam logic [23:0] FLASH_MASK = 24'(FLASH_BYTES - 1);

  wire [7:0]  bank   = cpu_addr[23:16];
  wire        upper  = cpu_addr[15];

  wire [23:0] rom_fold = {4'b0, cpu_addr[20:16], cpu_addr[14:0]};
  wire [23:0] fb_fold  = {2'b0, cpu_addr[22:16], cpu_addr[14:0]};
  wire [23:0] fb_lin   = {1'b0, cpu_addr[22:0]};
  wire [23:0] ram_wide = {4'b0, cpu_addr[19:0]};
  wire [23:0] ram_70   = {5'b0, cpu_addr[18:0]};

  wire hit_rom_lo = (bank <= 8'h1F) && upper && flags[F_ROM_LO];
  wire hit_rom_hi = (bank[7:5] == 3'b100) && upper && flags[F_ROM_HI];
  wire hit_ram_sm = (bank[7:5] == 3'b001) && (cpu_addr[15:13] == 3'b011);
  wire hit_ram40  = (bank[7:4] == 4'h4) && !flags[F_HIDE40];
  wire hit_ram50  = (bank[7:4] == 4'h5) && !flags[F_HIDE50];
  wire hit_ram60  = (bank[7:4] == 4'h6) && flags[F_RAM60];
  wire hit_ram70  = (bank[7:3] == 5'b01110);
  wire hit_fb     = bank[6] || upper;

  logic [3:0]  sel_d;
  logic [23:0] raw_d;
  logic [23:0] mask_d;

  always_comb begin
    sel_d = S_OPEN;
    raw_d = 24'h0;
    if (hit_rom_lo || hit_rom_hi) begin
      sel_d = S_ROM;
      raw_d = rom_fold;
    end else if (hit_ram_sm) begin
      sel_d = S_RAM;
      raw_d = cpu_addr;
    end else if (hit_ram40 || hit_ram50 || hit_ram60) begin
      sel_d = S_RAM;
      raw_d = ram_wide;
    end else if (hit_ram70) begin
      sel_d = S_RAM;
      raw_d = ram_70;
    end else if (hit_fb) begin
      sel_d = flags[F_FB_RAM] ? S_RAM : S_FLASH;
      raw_d = flags[F_LINEAR] ? fb_lin : fb_fold;
    end
  end

  always_comb begin
    case (sel_d)
      S_ROM:   mask_d = ROM_MASK;
      S_RAM:   mask_d = RAM_MASK;
      S_FLASH: mask_d = FLASH_MASK;
      default: mask_d = 24'h0;
    endcase
  end

  wire [23:0] mirrored = raw_d & mask_d;

  logic [7:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_sel   <= S_OPEN;
      phys_addr <= '0;
      open_data <= 8'h00;
      last_q    <= 8'h00;
    end else begin
      tgt_sel   <= sel_d;
      phys_addr <= mirrored[PA_W-1:0];
      open_data <= sel_d[3] ? last_q : 8'h00;
      last_q    <= bus_data;
    end
  end

  assign open_bus = tgt_sel[3];
endmodule

module cart_addr_mapper_chk #(
  parameter int ROM_BYTES   = 512 * 1024,
  parameter int RAM_BYTES   = 512 * 1024,
  parameter int FLASH_BYTES = 4 * 1024 * 1024,
  parameter int PA_W        = 22
) (
  input logic            clk,
  input logic            rst_n,
  input logic [23:0]     cpu_addr,
  input logic [15:0]     flags,
  input logic [3:0]      tgt_sel,
  input logic [PA_W-1:0] phys_addr
);
  wire [23:0] pa = 24'(phys_addr);

  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tgt_sel) == 1);

  assert_rom_lo_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[23:16] <= 8'h1F && cpu_addr[15] && flags[7]) |=> tgt_sel == 4'b0001);

  assert_ram_win_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[23:21] == 3'b001 && cpu_addr[15:13] == 3'b011)
      |=> (tgt_sel == 4'b0010 && pa == ($past(cpu_addr) & 24'(RAM_BYTES - 1))));

  assert_ram70_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[23:19] == 5'b01110)
      |=> (tgt_sel == 4'b0010 && pa == ($past(cpu_addr) & 24'(RAM_BYTES - 1))));

  assert_open_addr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[3] |-> pa == 24'h0);

  assert_rom_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[0] |-> pa < 24'(ROM_BYTES));

  assert_ram_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[1] |-> pa < 24'(RAM_BYTES));

  assert_flash_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[2] |-> pa < 24'(FLASH_BYTES));
endmodule

bind cart_addr_mapper cart_addr_mapper_chk #(
  .ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES),
  .FLASH_BYTES(FLASH_BYTES), .PA_W(PA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .flags(flags),
  .tgt_sel(tgt_sel), .phys_addr(phys_addr)
);

// File: tb/cart_addr_mapper_test.sv
module cart_addr_mapper_test;
  localparam int PA_W = 22;
  localparam logic [3:0] ROM = 4'b0001, RAM = 4'b0010, FLS = 4'b0100, OPN = 4'b1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [7:0]  bus_data = '0;
  logic [15:0] flags = '0;
  logic [3:0]  tgt_sel;
  logic [PA_W-1:0] phys_addr;
  logic open_bus;
  logic [7:0] open_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cart_addr_mapper uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .bus_data(bus_data),
    .flags(flags), .tgt_sel(tgt_sel), .phys_addr(phys_addr),
    .open_bus(open_bus), .open_data(open_data)
  );

  task automatic expect_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic probe(input string req, input logic [23:0] a, input logic [15:0] f,
                       input logic [3:0] es, input logic [23:0] ea);
    @(negedge clk);
    cpu_addr = a;
    flags = f;
    @(negedge clk);
    expect_eq(req, $sformatf("sel @%h/%h", a, f), 32'(tgt_sel), 32'(es));
    expect_eq(req, $sformatf("addr @%h/%h", a, f), 32'(phys_addr), 32'(ea));
    expect_eq(req, "open_bus", 32'(open_bus), 32'(es == OPN));
  endtask

  task automatic t_reset;
    @(negedge clk);
    expect_eq("R10", "reset sel", 32'(tgt_sel), 32'(OPN));
    expect_eq("R10", "reset addr", 32'(phys_addr), 32'h0);
    expect_eq("R10", "reset data", 32'(open_data), 32'h0);
  endtask

  task automatic t_rom;
    probe("R1", 24'h1F9234, 16'h0080, ROM, 24'h079234);
    probe("R1", 24'h058000, 16'h0080, ROM, 24'h028000);
    probe("R1", 24'h1F9234, 16'h0000, FLS, 24'h0F9234);
    probe("R2", 24'h85ABCD, 16'h0100, ROM, 24'h02ABCD);
    probe("R2", 24'h85ABCD, 16'h0006, RAM, 24'h05ABCD);
    probe("R2", 24'h85ABCD, 16'h0080, FLS, 24'h02ABCD);
  endtask

  task automatic t_ram_windows;
    probe("R3", 24'h2A6F00, 16'hFFFF, RAM, 24'h026F00);
    probe("R3", 24'h3F7FFF, 16'h0000, RAM, 24'h077FFF);
    probe("R3", 24'h2A5FFF, 16'h0000, OPN, 24'h000000);
    probe("R4", 24'h4ABCDE, 16'h0000, RAM, 24'h02BCDE);
    probe("R4", 24'h4ABCDE, 16'h0020, FLS, 24'h253CDE);
    probe("R4", 24'h512345, 16'h0020, RAM, 24'h012345);
    probe("R4", 24'h512345, 16'h0040, FLS, 24'h28A345);
    probe("R5", 24'h6789AB, 16'h0008, RAM, 24'h0789AB);
    probe("R5", 24'h6789AB, 16'h0000, FLS, 24'h3389AB);
    probe("R6", 24'h75CAFE, 16'h0000, RAM, 24'h05CAFE);
    probe("R6", 24'h78CAFE, 16'h0000, FLS, 24'h3C4AFE);
  endtask

  task automatic t_fallback;
    probe("R7", 24'hC12345, 16'h0004, FLS, 24'h012345);
    probe("R7", 24'hC12345, 16'h0000, FLS, 24'h20A345);
    probe("R7", 24'hC1A345, 16'h0000, FLS, 24'h20A345);
    probe("R7", 24'hC12345, 16'h0006, RAM, 24'h012345);
    probe("R9", 24'hFFFFFF, 16'h0004, FLS, 24'h3FFFFF);
    probe("R11", 24'hC12345, 16'hFE11, FLS, 24'h20A345);
    probe("R11", 24'h75CAFE, 16'hFE11, RAM, 24'h05CAFE);
  endtask

  task automatic t_open;
    probe("R8", 24'h001234, 16'hFFFF, OPN, 24'h000000);
    probe("R8", 24'h9F7FFF, 16'h0000, OPN, 24'h000000);
    @(negedge clk);
    bus_data = 8'h5A;
    cpu_addr = 24'hC00000;
    @(negedge clk);
    cpu_addr = 24'h800000;
    bus_data = 8'hC3;
    @(negedge clk);
    expect_eq("R8", "open_data prev cycle", 32'(open_data), 32'h5A);
    cpu_addr = 24'hC00000;
    @(negedge clk);
    expect_eq("R8", "open_data on mapped", 32'(open_data), 32'h00);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_rom();
    t_ram_windows();
    t_fallback();
    t_open();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule